// File: doc/BRIEF.md
# Nibble-Multiplexed Instruction Fetch Sequencer

This block is the processor-side fetch controller for a system where the processor and its program memories share one 4-bit bidirectional data bus. All transfers are time-multiplexed over a fixed instruction cycle of eight clock phases. In the first three phases the processor sends a 12-bit fetch address, one nibble per phase. In the next two phases it releases the bus and the selected memory returns an 8-bit instruction, one nibble per phase. The last three phases are left for execution. A sync output marks the first phase of every cycle so that each memory device can keep its own phase count aligned with the processor.

The block holds a 12-bit program counter. The counter indexes 8-bit instruction words, not bits, so it reaches 4096 words. The top address nibble acts as the chip-select code for one of sixteen memory devices. The counter is cleared by reset and advances by one after every fetch. The only instruction the block decodes is the unconditional jump. A jump takes two words, fetched in two consecutive cycles, and after the second word the counter is loaded with the 12-bit target. The fetched byte appears on `instr_o` for the execution datapath, which lies outside this block.

Top module: `nibble_fetch_seq`

## Requirements
- R1: While `rst_ni` is low the block holds phase A1 (`phase_o` = 0), `sync_o` = 1, `instr_o` = 0 and a program counter of 0. The first fetch after reset goes to address 0x000.
- R2: `phase_o` steps through 0..7 in the order A1, A2, A3, M1, M2, X1, X2, X3, advancing once per clock, and wraps from 7 back to 0.
- R3: `sync_o` is 1 during phase A1 of every cycle and 0 in every other phase.
- R4: `bus_oe_o` is 1 in A1, A2 and A3. In those phases `bus_o` carries PC[3:0] in A1, PC[7:4] in A2 and PC[11:8] (the chip-select code) in A3.
- R5: `bus_oe_o` is 0 in M1, M2, X1, X2 and X3, and `bus_o` reads 0 in those phases.
- R6: `bus_i` is sampled on the rising edge that ends M1, giving instruction bits [7:4], and on the rising edge that ends M2, giving bits [3:0]. `instr_o` shows the new byte from X1 onward and holds it until the end of the next M2. `bus_i` has no effect in any other phase.
- R7: After a fetch that is not the second word of a jump, the program counter increments by one. It wraps from 0xFFF to 0x000.
- R8: A byte whose bits [7:4] equal 4'h4 is a jump. Its bits [3:0] are target[11:8]. The byte fetched in the next cycle, from PC+1, is target[7:0], and the following fetch goes to the target.
- R9: The second word of a jump is never decoded as an opcode, even when its bits [7:4] equal 4'h4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one phase per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_i | input | 4 | Nibble read from the shared bus |
| bus_o | output | 4 | Nibble driven onto the shared bus |
| bus_oe_o | output | 1 | Drive enable for `bus_o` |
| sync_o | output | 1 | High during the first phase of each cycle |
| instr_o | output | 8 | Last fetched instruction byte |
| phase_o | output | 3 | Current phase, 0 = A1 .. 7 = X3 |

## Verification
The bench runs a program that jumps into the top of the address space, so the counter must wrap from 0xFFF to 0x000. A design that drops the carry or overflows into a thirteenth bit sends the wrong address nibbles in A3 after the wrap. The second word of one jump is 0x4E, which carries the jump opcode. A design that decodes that word starts a false jump and fetches from the wrong address. The bench drives junk on `bus_i` outside M1 and M2 and checks `instr_o` in every phase. This catches swapped nibble order, capture in the wrong phase, and an output that changes before X1. The drive enable is checked in every phase, so a design that drives the bus while the memory answers is reported.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
  localparam int unsigned NUM_PH = 8;
  localparam int unsigned PH_W   = $clog2(NUM_PH);

  typedef enum logic [PH_W-1:0] {
    PH_A1 = 3'd0,
    PH_A2 = 3'd1,
    PH_A3 = 3'd2,
    PH_M1 = 3'd3,
    PH_M2 = 3'd4,
    PH_X1 = 3'd5,
    PH_X2 = 3'd6,
    PH_X3 = 3'd7
  } phase_e;
endpackage

// File: rtl/nfs_phase_ctr.sv
module nfs_phase_ctr
  import nfs_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  output phase_e phase_o,
  output logic   sync_o
);
  phase_e phase_q;
  logic   sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_A1;
      sync_q  <= 1'b1;
    end else begin
      phase_q <= phase_e'(phase_q + 1'b1);
      sync_q  <= (phase_q == PH_X3);
    end
  end

  assign phase_o = phase_q;
  assign sync_o  = sync_q;

  // R2
  cycle_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_X3 |=> phase_q == PH_A1);

  // R3
  sync_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_q |=> !sync_q);
endmodule

// File: rtl/nfs_pc.sv
module nfs_pc #(
  parameter int unsigned PC_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            inc_i,
  input  logic            load_i,
  input  logic [PC_W-1:0] target_i,
  output logic [PC_W-1:0] pc_o
);
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (load_i) pc_q <= target_i;
    else if (inc_i)  pc_q <= pc_q + PC_W'(1);
  end

  assign pc_o = pc_q;

  // R7
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> pc_q == $past(pc_q) + PC_W'(1));

  // R7
  pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !load_i) |=> $stable(pc_q));

  // R8
  pc_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> pc_q == $past(target_i));
endmodule

// File: rtl/nfs_addr_drv.sv
module nfs_addr_drv
  import nfs_pkg::*;
#(
  parameter int unsigned PC_W  = 12,
  parameter int unsigned NIB_W = 4
) (
  input  phase_e           phase_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic [NIB_W-1:0] bus_o,
  output logic             bus_oe_o
);
  localparam int unsigned ADDR_NIBS = PC_W / NIB_W;

  logic [NIB_W-1:0] nib [ADDR_NIBS];

  for (genvar g = 0; g < ADDR_NIBS; g++) begin : g_nib
    assign nib[g] = pc_i[g*NIB_W +: NIB_W];
  end

  // address phases start at A1, low nibble first
  always_comb begin
    bus_o    = '0;
    bus_oe_o = 1'b0;
    for (int k = 0; k < ADDR_NIBS; k++) begin
      if (phase_i == phase_e'(k)) begin
        bus_o    = nib[k];
        bus_oe_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nibble_fetch_seq.sv
module nibble_fetch_seq
  import nfs_pkg::*;
#(
  parameter int unsigned PC_W   = 12,
  parameter int unsigned NIB_W  = 4,
  parameter logic [3:0]  JMP_OP = 4'h4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NIB_W-1:0]   bus_i,
  output logic [NIB_W-1:0]   bus_o,
  output logic               bus_oe_o,
  output logic               sync_o,
  output logic [2*NIB_W-1:0] instr_o,
  output logic [PH_W-1:0]    phase_o
);
  localparam int unsigned WORD_W = 2 * NIB_W;
  localparam int unsigned HI_W   = PC_W - WORD_W;

  phase_e            phase;
  logic [PC_W-1:0]   pc;
  logic [NIB_W-1:0]  ir_hi_q;
  logic [WORD_W-1:0] instr_q;
  logic              jmp_pend_q;
  logic [HI_W-1:0]   jmp_hi_q;
  logic [WORD_W-1:0] fetched;
  logic              end_m1, end_m2, pc_inc, pc_load;

  nfs_phase_ctr u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase),
    .sync_o  (sync_o)
  );

  assign end_m1  = (phase == PH_M1);
  assign end_m2  = (phase == PH_M2);
  assign fetched = {ir_hi_q, bus_i};
  assign pc_inc  = end_m2 && !jmp_pend_q;
  assign pc_load = end_m2 && jmp_pend_q;

  nfs_pc #(.PC_W(PC_W)) u_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (pc_inc),
    .load_i   (pc_load),
    .target_i ({jmp_hi_q, fetched}),
    .pc_o     (pc)
  );

  nfs_addr_drv #(.PC_W(PC_W), .NIB_W(NIB_W)) u_addr (
    .phase_i  (phase),
    .pc_i     (pc),
    .bus_o    (bus_o),
    .bus_oe_o (bus_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ir_hi_q    <= '0;
      instr_q    <= '0;
      jmp_pend_q <= 1'b0;
      jmp_hi_q   <= '0;
    end else begin
      if (end_m1) ir_hi_q <= bus_i;
      if (end_m2) begin
        instr_q <= fetched;
        if (jmp_pend_q) begin
          jmp_pend_q <= 1'b0;  // operand word: never decoded
        end else if (fetched[WORD_W-1 -: 4] == JMP_OP) begin
          jmp_pend_q <= 1'b1;
          jmp_hi_q   <= fetched[HI_W-1:0];
        end
      end
    end
  end

  assign instr_o = instr_q;
  assign phase_o = phase;

  // R5
  bus_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_M1 || phase == PH_M2) |-> !bus_oe_o);

  // R3
  sync_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> bus_oe_o);

  // R6
  instr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_X1) |-> $stable(instr_o));

  // R9
  pend_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_m2 && jmp_pend_q) |=> !jmp_pend_q);
endmodule

// File: tb/tb_nibble_fetch_seq.sv
module tb_nibble_fetch_seq;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [3:0] bus_i;
  logic [3:0] bus_o;
  logic       bus_oe_o;
  logic       sync_o;
  logic [7:0] instr_o;
  logic [2:0] phase_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [11:0] exp_addr_q[$];
  logic [7:0]  exp_ins_q[$];

  always #5 clk_i = ~clk_i;

  nibble_fetch_seq dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bus_i    (bus_i),
    .bus_o    (bus_o),
    .bus_oe_o (bus_oe_o),
    .sync_o   (sync_o),
    .instr_o  (instr_o),
    .phase_o  (phase_o)
  );

  // program memory image, 0x4_ = jump opcode
  function automatic logic [7:0] mem(input logic [11:0] a);
    case (a)
      12'h000: return 8'h10;
      12'h001: return 8'h4A;  // R8 jump, target hi = A
      12'h002: return 8'h55;
      12'hA55: return 8'h4F;
      12'hA56: return 8'h4E;  // R9 operand that looks like a jump
      12'hF4E: return 8'h4F;
      12'hF4F: return 8'hFE;
      12'hFFE: return 8'h21;
      12'hFFF: return 8'h33;  // R7 wrap to 0x000 follows
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic push_expected(input int n_cyc);
    logic [11:0] pc = 12'h000;
    logic [3:0]  hi = 4'h0;
    bit          pend = 0;
    for (int i = 0; i < n_cyc; i++) begin
      logic [7:0] b;
      b = mem(pc);
      exp_addr_q.push_back(pc);
      exp_ins_q.push_back(b);
      if (pend) begin
        pc   = {hi, b};
        pend = 0;
      end else if (b[7:4] == 4'h4) begin
        hi   = b[3:0];
        pend = 1;
        pc   = pc + 12'd1;
      end else begin
        pc = pc + 12'd1;
      end
    end
  endtask

  initial begin
    logic [11:0] addr;
    logic [7:0]  last_ins;
    logic [7:0]  cur;
    rst_ni = 1'b0;
    bus_i  = 4'h9;
    push_expected(30);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R1 reset state
    chk(phase_o == 3'd0, "R1 phase", phase_o, 0);
    chk(sync_o == 1'b1, "R1 sync", sync_o, 1);
    chk(instr_o == 8'h00, "R1 instr", instr_o, 0);
    chk(bus_o == 4'h0, "R1 pc nibble", bus_o, 0);
    rst_ni   = 1'b1;
    last_ins = 8'h00;
    addr     = '0;
    cur      = '0;
    while (exp_addr_q.size() > 0) begin
      for (int ph = 0; ph < 8; ph++) begin
        chk(phase_o == 3'(ph), "R2 phase order", phase_o, ph);
        chk(sync_o == (ph == 0), "R3 sync", sync_o, (ph == 0));
        if (ph < 3) begin
          chk(bus_oe_o == 1'b1, "R4 drive enable", bus_oe_o, 1);
          addr[ph*4 +: 4] = bus_o;
          if (ph == 2) begin
            logic [11:0] ea;
            ea = exp_addr_q.pop_front();
            // R1 R4 R7 R8 R9: fetch address sequence
            chk(addr == ea, "R4/R7/R8/R9 fetch address", addr, ea);
            cur = mem(addr);
          end
        end else begin
          chk(bus_oe_o == 1'b0, "R5 released", bus_oe_o, 0);
          chk(bus_o == 4'h0, "R5 bus_o idle", bus_o, 0);
        end
        if (ph == 5) last_ins = exp_ins_q.pop_front();
        chk(instr_o == last_ins, "R6 instr", instr_o, last_ins);
        // R6: junk outside M1/M2 must not be captured
        if (ph == 3)      bus_i = cur[7:4];
        else if (ph == 4) bus_i = cur[3:0];
        else              bus_i = 4'(ph) ^ 4'hA;
        @(posedge clk_i);
        @(negedge clk_i);
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule